// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU

This block is a purely combinational arithmetic and logic unit of parameterised width (32 bits by default). It is assembled from a chain of identical one-bit slices. Each slice may complement either operand bit. It then forms the AND, the OR and the full-adder sum of the two bits and passes one of the four candidates (AND, OR, sum, or a "less" input) to its result bit. Carries ripple upward from slice to slice. The most significant slice is a variant that also exposes its raw sum bit and the signed-overflow flag.

Callers drive a 4-bit control word, `{inv_a, inv_b, sel[1:0]}`. Subtraction, NOR and set-less-than need no opcodes of their own; they fall out of the invert bits and the shared select. `inv_b` doubles as the carry into bit 0, so that complementing B yields A + ~B + 1. Set-less-than routes the top slice's sum bit back to the less input of bit 0, while every other slice sees a constant 0 there. A zero flag across the whole result lets an equal / not-equal branch follow a subtract.

Top module: `slice_alu`

## Requirements
- R1: With control word 4'b0000 (`inv_a`=0, `inv_b`=0, `sel`=00) the result is `op_a & op_b`.
- R2: With control word 4'b0001 the result is `op_a | op_b`.
- R3: With control word 4'b0010 the result is `op_a + op_b` modulo 2^WIDTH, and `carry_out` is the carry leaving the most significant bit.
- R4: With control word 4'b0110 the result is `op_a - op_b` modulo 2^WIDTH, computed as A + ~B + 1, so `carry_out` is 1 exactly when `op_a >= op_b` taken as unsigned.
- R5: With control word 4'b1100 the result is `~(op_a | op_b)`.
- R6: With control word 4'b0111 the result bits WIDTH-1..1 are 0 and bit 0 equals the most significant bit of `op_a - op_b`; when that subtraction does not overflow, bit 0 equals signed `op_a < op_b`.
- R7: `overflow` is 1 exactly when the carry into the most significant slice differs from the carry out of it; for add and subtract this is two's-complement overflow.
- R8: `zero` is 1 exactly when every result bit is 0.
- R9: For every one of the 16 control words, A is complemented when `inv_a`=1 and B when `inv_b`=1, the carry into bit 0 equals `inv_b`, and `sel` picks 00 AND, 01 OR, 10 sum, 11 less for every bit. For example, 4'b1010 yields ~A + B.
- R10: The adder runs under every select, so `carry_out` and `overflow` reflect the inverted-operand sum even when `sel` chooses a logic result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| ctrl | input | 4 | Control word {inv_a, inv_b, sel[1:0]} |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Carry into top slice XOR carry out of it |
| zero | output | 1 | All result bits are 0 |

## Verification
The bench targets carries that travel the full chain, such as all-ones plus one and zero minus one. A design that broke the ripple or fed the wrong carry-in would return a result off by one, or a wrong `carry_out`. Overflow corners are the largest positive plus one and the most negative minus one. A flag taken from the wrong carry pair would miss these, or fire on ordinary sums whose operands have opposite signs. For set-less-than the bench uses mixed-sign pairs and equal operands. If the top sum bit were not looped back to bit 0, or a higher less input were left live, the result would show a stray upper bit or a constant. Sweeping all sixteen control words catches a swapped invert line or a mis-decoded select, because unlisted codes such as ~A + B then go wrong.

// File: rtl/slice_alu_pkg.sv
// Shared types and bit-level helpers for the sliced ALU.
// Assumes: single-bit operations only; all users are combinational.
package slice_alu_pkg;

    // Per-slice output select
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    // Control word as seen at the top port
    typedef struct packed {
        logic       inv_a;
        logic       inv_b;
        slice_sel_e sel;
    } alu_ctrl_t;

    // Named control words
    localparam logic [3:0] CW_AND = 4'b0000;
    localparam logic [3:0] CW_OR  = 4'b0001;
    localparam logic [3:0] CW_ADD = 4'b0010;
    localparam logic [3:0] CW_SUB = 4'b0110;
    localparam logic [3:0] CW_SLT = 4'b0111;
    localparam logic [3:0] CW_NOR = 4'b1100;

    // Odd parity of the three adder inputs
    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    // Majority of the three adder inputs
    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (y & c) | (x & c) | (x & y);
    endfunction

    // Four-way result pick inside one slice
    function automatic logic slice_pick(input slice_sel_e s, input logic f_and,
                                        input logic f_or, input logic f_sum,
                                        input logic f_less);
        logic r;
        case (s)
            SEL_AND:  r = f_and;
            SEL_OR:   r = f_or;
            SEL_SUM:  r = f_sum;
            default:  r = f_less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slice_alu_bit.sv
// One ordinary ALU slice (any bit but the most significant).
// Optionally complements each operand bit, forms AND/OR/sum, and picks one.
// Assumes: carry arrives from the slice below; less is 0 except at bit 0.
module slice_alu_bit
    import slice_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  slice_sel_e sel_i,
    input  logic       carry_i,
    input  logic       less_i,
    output logic       res_o,
    output logic       carry_o
);

    logic a_eff;
    logic b_eff;
    logic sum_bit;

    // Operand conditioning, adder and result pick for this bit
    always_comb begin
        a_eff   = a_i ^ inv_a_i;
        b_eff   = b_i ^ inv_b_i;
        sum_bit = fa_sum(a_eff, b_eff, carry_i);
        carry_o = fa_carry(a_eff, b_eff, carry_i);
        res_o   = slice_pick(sel_i, a_eff & b_eff, a_eff | b_eff, sum_bit, less_i);
    end

endmodule

// File: rtl/slice_alu_msb.sv
// Most significant ALU slice.
// Same datapath as an ordinary slice, plus the raw sum bit (set) that feeds
// set-less-than, and the overflow flag from its carry-in/carry-out pair.
// Assumes: its own less input is tied to 0 by the parent.
module slice_alu_msb
    import slice_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  slice_sel_e sel_i,
    input  logic       carry_i,
    input  logic       less_i,
    output logic       res_o,
    output logic       carry_o,
    output logic       set_o,
    output logic       ovf_o
);

    logic a_eff;
    logic b_eff;

    // Operand conditioning, adder, pick, set and overflow for the top bit
    always_comb begin
        a_eff   = a_i ^ inv_a_i;
        b_eff   = b_i ^ inv_b_i;
        set_o   = fa_sum(a_eff, b_eff, carry_i);
        carry_o = fa_carry(a_eff, b_eff, carry_i);
        ovf_o   = carry_i ^ carry_o;
        res_o   = slice_pick(sel_i, a_eff & b_eff, a_eff | b_eff, set_o, less_i);
    end

endmodule

// File: rtl/slice_alu_zero.sv
// Zero detect over the assembled result, as a balanced OR tree.
// Assumes: WIDTH >= 1; purely combinational.
module slice_alu_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             zero_o
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int PADDED = 1 << LEVELS;

    logic [2*PADDED-2:0] node;

    // Leaves: result bits, padded with zeros
    genvar gi;
    generate
        for (gi = 0; gi < PADDED; gi++) begin : g_leaf
            if (gi < WIDTH) begin : g_real
                assign node[PADDED-1+gi] = vec_i[gi];
            end else begin : g_pad
                assign node[PADDED-1+gi] = 1'b0;
            end
        end
        for (gi = 0; gi < PADDED-1; gi++) begin : g_or
            assign node[gi] = node[2*gi+1] | node[2*gi+2];
        end
    endgenerate

    // Root of the tree inverted gives the flag
    assign zero_o = ~node[0];

endmodule

// File: rtl/slice_alu.sv
// Top of the bit-sliced ripple ALU.
// Chains WIDTH slices through a ripple carry; bit 0 takes carry-in from
// inv_b and its less input from the top slice's set output.
// Assumes: WIDTH >= 2; no clock, no state.
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       ctrl,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);

    localparam int TOP = WIDTH - 1;

    alu_ctrl_t  cw;
    logic [WIDTH:0] carry;
    logic           set_bit;

    // Unpack the control word and seed the carry chain
    always_comb begin
        cw       = alu_ctrl_t'(ctrl);
        carry[0] = cw.inv_b;
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_slice
            if (gi == TOP) begin : g_top
                slice_alu_msb u_msb (
                    .a_i     (op_a[gi]),
                    .b_i     (op_b[gi]),
                    .inv_a_i (cw.inv_a),
                    .inv_b_i (cw.inv_b),
                    .sel_i   (cw.sel),
                    .carry_i (carry[gi]),
                    .less_i  (1'b0),
                    .res_o   (result[gi]),
                    .carry_o (carry[gi+1]),
                    .set_o   (set_bit),
                    .ovf_o   (overflow)
                );
            end else if (gi == 0) begin : g_low
                slice_alu_bit u_bit (
                    .a_i     (op_a[gi]),
                    .b_i     (op_b[gi]),
                    .inv_a_i (cw.inv_a),
                    .inv_b_i (cw.inv_b),
                    .sel_i   (cw.sel),
                    .carry_i (carry[gi]),
                    .less_i  (set_bit),
                    .res_o   (result[gi]),
                    .carry_o (carry[gi+1])
                );
            end else begin : g_mid
                slice_alu_bit u_bit (
                    .a_i     (op_a[gi]),
                    .b_i     (op_b[gi]),
                    .inv_a_i (cw.inv_a),
                    .inv_b_i (cw.inv_b),
                    .sel_i   (cw.sel),
                    .carry_i (carry[gi]),
                    .less_i  (1'b0),
                    .res_o   (result[gi]),
                    .carry_o (carry[gi+1])
                );
            end
        end
    endgenerate

    // Carry leaving the chain
    assign carry_out = carry[WIDTH];

    slice_alu_zero #(.WIDTH(WIDTH)) u_zero (
        .vec_i  (result),
        .zero_o (zero)
    );

endmodule

// File: rtl/slice_alu_chk.sv
// Property checker for slice_alu, bound to every instance.
// Assumes: inputs settle before evaluation; checks are immediate, on ports.
module slice_alu_chk
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       ctrl,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow,
    input logic             zero
);

    // Port-level relations per control word
    always_comb begin
        if (ctrl == CW_AND) AST_AND_RESULT: assert (result == (op_a & op_b)); // R1
        if (ctrl == CW_OR)  AST_OR_RESULT:  assert (result == (op_a | op_b)); // R2
        if (ctrl == CW_NOR) AST_NOR_RESULT: assert (result == ~(op_a | op_b)); // R5
        if (ctrl == CW_SLT) AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0); // R6
        if (ctrl == CW_SUB && op_a == op_b) AST_SUB_EQUAL: assert (zero && carry_out); // R4
        if (ctrl == CW_ADD && (op_a[WIDTH-1] != op_b[WIDTH-1])) AST_NO_OVERFLOW: assert (!overflow); // R7
        if (ctrl == CW_AND && op_a == '0) AST_ZERO_AND: assert (zero); // R8
    end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/slice_alu_tb.sv
// Bench for slice_alu: behavioural reference model compared every clock.
module slice_alu_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   ctrl = 4'b0000;
    logic [W-1:0] result;
    logic         carry_out;
    logic         overflow;
    logic         zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    slice_alu #(.WIDTH(W)) u_dut (
        .op_a(op_a), .op_b(op_b), .ctrl(ctrl),
        .result(result), .carry_out(carry_out),
        .overflow(overflow), .zero(zero)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (a=%h b=%h ctrl=%b)",
                     req, what, act, exp, op_a, op_b, ctrl);
        end
    endtask

    // Drive one vector, then compare against the reference at the negedge
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] c, input string req);
        logic [W-1:0] ea, eb, exp_res;
        logic [W:0]   full;
        logic         exp_ovf;
        @(posedge clk);
        op_a = a; op_b = b; ctrl = c;
        ea   = c[3] ? ~a : a;
        eb   = c[2] ? ~b : b;
        full = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, c[2]};
        exp_ovf = (ea[W-1] == eb[W-1]) && (full[W-1] != ea[W-1]);
        case (c[1:0])
            2'b00: exp_res = ea & eb;
            2'b01: exp_res = ea | eb;
            2'b10: exp_res = full[W-1:0];
            default: exp_res = {{(W-1){1'b0}}, full[W-1]};
        endcase
        @(negedge clk);
        check(req, "result", result, exp_res);
        check("R10", "carry_out", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, full[W]});
        check("R7", "overflow", {{(W-1){1'b0}}, overflow}, {{(W-1){1'b0}}, exp_ovf});
        check("R8", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (exp_res == '0)});
        // R6: signed comparison when the subtraction cannot overflow
        if (c == 4'b0111 && !exp_ovf)
            check("R6", "slt_signed", result,
                  {{(W-1){1'b0}}, ($signed(a) < $signed(b))});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset-time state: all-zero inputs with AND give zero result
        check("R8", "reset_result", result, '0);
        check("R8", "reset_zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        rst_n = 1'b1;

        // R1 / R2 / R5 logic patterns
        run(32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0000, "R1");
        run(32'hAAAA_5555, 32'h5555_AAAA, 4'b0000, "R1");
        run(32'hF0F0_1234, 32'h0FF0_0000, 4'b0001, "R2");
        run(32'h0000_0000, 32'h0000_0000, 4'b0001, "R2");
        run(32'h0000_0000, 32'h0000_0000, 4'b1100, "R5");
        run(32'h8000_0001, 32'h0000_0100, 4'b1100, "R5");
        // R3 add: full ripple, overflow corners
        run(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, "R3");
        run(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "R3");
        run(32'h8000_0000, 32'h8000_0000, 4'b0010, "R3");
        run(32'h1234_5678, 32'h8765_4321, 4'b0010, "R3");
        // R4 subtract: borrow, equal, overflow
        run(32'h0000_0000, 32'h0000_0001, 4'b0110, "R4");
        run(32'h0000_0005, 32'h0000_0005, 4'b0110, "R4");
        run(32'h8000_0000, 32'h0000_0001, 4'b0110, "R4");
        run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110, "R4");
        // R6 set-less-than: mixed signs, equal, overflowing pair
        run(32'hFFFF_FFFF, 32'h0000_0001, 4'b0111, "R6");
        run(32'h0000_0001, 32'hFFFF_FFFF, 4'b0111, "R6");
        run(32'h0000_0007, 32'h0000_0007, 4'b0111, "R6");
        run(32'h0000_0003, 32'h0000_0009, 4'b0111, "R6");
        run(32'h8000_0000, 32'h0000_0001, 4'b0111, "R6");
        // R9 every control word with random operands
        for (int c = 0; c < 16; c++) begin
            run(32'h0000_0000, 32'hFFFF_FFFF, 4'(c), "R9");
            for (int k = 0; k < 40; k++)
                run($urandom, $urandom, 4'(c), "R9");
        end
        // R6 random signed compares on small values
        for (int k = 0; k < 50; k++)
            run($urandom & 32'h8000_00FF, $urandom & 32'h8000_00FF, 4'b0111, "R6");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule